// File: doc/BRIEF.md
# Per-Reference Running Mean Updater

This block holds a small table of learned references for a nearest-match classifier. For every slot it stores five things: the active reference vector, the active distance threshold, a running mean of the input vectors matched to the slot, a running mean of the winner-to-input distances, and a match counter. A classification result gives the block three items: the winner slot index, the input vector and the winner distance. The block then decides whether the input belongs to the winner or must become a new reference, and it updates the slot table.

The running means use a subtract-and-shift step instead of a divider. The shift is applied only when the sample count is a multiple of eight. The active vector and threshold are refreshed from the means only after the counter passes a limit. A new reference takes a slot chosen round-robin and is seeded from the input vector and a fixed starting threshold. A combinational read port exposes any slot to the classifier.

The control is a three-state machine:
- IDLE accepts a result.
- IDLE goes to MATCH when the distance is within the winner's threshold.
- IDLE goes to ALLOC when the distance is outside the winner's threshold.
- MATCH returns to IDLE unconditionally. In MATCH the winner's means, counter and active values are written.
- ALLOC returns to IDLE unconditionally. In ALLOC the winner's distance mean and counter are written, and a fresh slot is seeded.

Top module: `ref_mean_updater`

## Requirements
- R1: `in_ready` is high exactly when the machine is in IDLE. A result is taken on a rising edge where `in_valid` and `in_ready` are both high. Each result costs one busy cycle, during which `in_ready` is low and `in_valid` is ignored.
- R2: The input counts as known when `in_dist` is less than or equal to the active threshold of slot `in_idx`, and as new otherwise. For a new input, `new_ref` is high for the single busy cycle.
- R3: While `new_ref` is high, `new_slot` gives the slot being seeded. Slots are handed out in the order 0, 1, 2 and so on, and after slot 31 the order wraps to 0.
- R4: Let n be the winner's counter plus one, saturating at 63. If n is a multiple of 8, each mean m with sample s becomes m − floor((m − s)/2^k), clamped to 0..255. The shift k is 3 at n=8, 4 at n=16 or n=24, and 5 at n≥32. If n is not a multiple of 8, the mean is left unchanged. The vector mean is stepped only for known inputs.
- R5: The winner's distance mean is stepped with `in_dist` by the R4 rule for both known and new inputs.
- R6: If n exceeds NTH (32), the active vector takes the vector mean after this step, the active threshold takes the distance mean after this step, and the counter becomes 1. Otherwise the counter becomes n, and the active vector and threshold keep their values.
- R7: A seeded slot gets `in_vec` as both its active vector and its vector mean, 10 as both its threshold and its distance mean, and 1 as its counter. Feature f of a vector is bits 8f+7..8f. If the seeded slot is also the winner, the seeding overrides the winner update.
- R8: While `rst_n` is low, every slot field is 0, the allocation order restarts at slot 0, `in_ready` is high and `new_ref` is low.
- R9: The `rd_*` outputs show the current contents of slot `rd_idx` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Classification result present |
| in_ready | output | 1 | Block can take a result |
| in_idx | input | 5 | Winner slot index |
| in_vec | input | 64 | Input vector, 8 features of 8 bits |
| in_dist | input | 8 | Winner-to-input distance |
| new_ref | output | 1 | Input is being stored as a new reference |
| new_slot | output | 5 | Slot receiving the new reference |
| rd_idx | input | 5 | Slot to read |
| rd_ref | output | 64 | Active reference vector of the read slot |
| rd_mean | output | 64 | Vector mean of the read slot |
| rd_dth | output | 8 | Active distance threshold of the read slot |
| rd_mdth | output | 8 | Distance mean of the read slot |
| rd_cnt | output | 6 | Match counter of the read slot |

## Verification
The assertions check on every cycle the handshake rhythm, the one-cycle life of `new_ref` outside IDLE, and the round-robin order of `new_slot`. They also check, when the limit is below the counter's ceiling, that a counter shown on the read port never exceeds NTH. The arithmetic itself only shows up in the bench's scenarios: the shift chosen at counts 8, 16, 24 and 32 and above, the rounding of negative differences, the clamp, the copy of means into active values at the 33rd sample, the distance mean moving on out-of-threshold inputs, and a seeded slot overriding the winner. The bench's behavioural model checks these through the read port.

// File: rtl/rmu_pkg.sv
package rmu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_MATCH = 2'd1,
        ST_ALLOC = 2'd2
    } rmu_state_e;

    // Shift for a count n; 0 means "no step at this count".
    function automatic int unsigned rmu_shift(input int unsigned n);
        if (n == 0 || (n % 8) != 0) return 0;
        if (n == 8)                  return 3;
        if (n < 32)                  return 4;
        return 5;
    endfunction

endpackage

// File: rtl/rmu_mean_step.sv
module rmu_mean_step
    import rmu_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 6
) (
    input  logic [W-1:0]  mean_i,
    input  logic [W-1:0]  sample_i,
    input  logic [CW-1:0] n_i,
    output logic [W-1:0]  mean_o
);

    int unsigned          sh;
    logic signed [W:0]    diff;
    logic signed [W:0]    q;
    logic signed [W+1:0]  wide;

    always_comb begin
        sh   = rmu_shift(32'(n_i));
        diff = $signed({1'b0, mean_i}) - $signed({1'b0, sample_i});
        q    = diff >>> sh;
        wide = $signed({2'b00, mean_i}) - $signed({q[W], q});
        if (sh == 0) begin
            mean_o = mean_i;
        end else if (wide < 0) begin
            mean_o = '0;
        end else if (wide > $signed({2'b00, {W{1'b1}}})) begin
            mean_o = {W{1'b1}};
        end else begin
            mean_o = wide[W-1:0];
        end
    end

endmodule

// File: rtl/rmu_slot_table.sv
module rmu_slot_table #(
    parameter int NSLOT = 32,
    parameter int VW    = 64,
    parameter int DW    = 8,
    parameter int CW    = 6,
    parameter int IW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    // read port A (winner)
    input  logic [IW-1:0] ra_idx,
    output logic [VW-1:0] ra_ref,
    output logic [VW-1:0] ra_mean,
    output logic [DW-1:0] ra_dth,
    output logic [DW-1:0] ra_mdth,
    output logic [CW-1:0] ra_cnt,
    // read port B (external)
    input  logic [IW-1:0] rb_idx,
    output logic [VW-1:0] rb_ref,
    output logic [VW-1:0] rb_mean,
    output logic [DW-1:0] rb_dth,
    output logic [DW-1:0] rb_mdth,
    output logic [CW-1:0] rb_cnt,
    // write port A (winner update)
    input  logic          wa_en,
    input  logic [IW-1:0] wa_idx,
    input  logic [VW-1:0] wa_ref,
    input  logic [VW-1:0] wa_mean,
    input  logic [DW-1:0] wa_dth,
    input  logic [DW-1:0] wa_mdth,
    input  logic [CW-1:0] wa_cnt,
    // write port B (seeding, has priority)
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic [VW-1:0] wb_vec,
    input  logic [DW-1:0] wb_dth,
    input  logic [CW-1:0] wb_cnt
);

    logic [VW-1:0] ref_q  [NSLOT];
    logic [VW-1:0] mean_q [NSLOT];
    logic [DW-1:0] dth_q  [NSLOT];
    logic [DW-1:0] mdth_q [NSLOT];
    logic [CW-1:0] cnt_q  [NSLOT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) begin
                ref_q[i]  <= '0;
                mean_q[i] <= '0;
                dth_q[i]  <= '0;
                mdth_q[i] <= '0;
                cnt_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (wb_en && wb_idx == IW'(i)) begin
                    ref_q[i]  <= wb_vec;
                    mean_q[i] <= wb_vec;
                    dth_q[i]  <= wb_dth;
                    mdth_q[i] <= wb_dth;
                    cnt_q[i]  <= wb_cnt;
                end else if (wa_en && wa_idx == IW'(i)) begin
                    ref_q[i]  <= wa_ref;
                    mean_q[i] <= wa_mean;
                    dth_q[i]  <= wa_dth;
                    mdth_q[i] <= wa_mdth;
                    cnt_q[i]  <= wa_cnt;
                end
            end
        end
    end

    assign ra_ref  = ref_q[ra_idx];
    assign ra_mean = mean_q[ra_idx];
    assign ra_dth  = dth_q[ra_idx];
    assign ra_mdth = mdth_q[ra_idx];
    assign ra_cnt  = cnt_q[ra_idx];

    assign rb_ref  = ref_q[rb_idx];
    assign rb_mean = mean_q[rb_idx];
    assign rb_dth  = dth_q[rb_idx];
    assign rb_mdth = mdth_q[rb_idx];
    assign rb_cnt  = cnt_q[rb_idx];

endmodule

// File: rtl/ref_mean_updater.sv
module ref_mean_updater
    import rmu_pkg::*;
#(
    parameter int NF       = 8,
    parameter int FW       = 8,
    parameter int NSLOT    = 32,
    parameter int CW       = 6,
    parameter int NTH      = 32,
    parameter int INIT_DTH = 10,
    localparam int VW      = NF * FW,
    localparam int IW      = $clog2(NSLOT),
    localparam int CMAX    = (1 << CW) - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [IW-1:0] in_idx,
    input  logic [VW-1:0] in_vec,
    input  logic [FW-1:0] in_dist,
    output logic          new_ref,
    output logic [IW-1:0] new_slot,
    input  logic [IW-1:0] rd_idx,
    output logic [VW-1:0] rd_ref,
    output logic [VW-1:0] rd_mean,
    output logic [FW-1:0] rd_dth,
    output logic [FW-1:0] rd_mdth,
    output logic [CW-1:0] rd_cnt
);

    rmu_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, ptr_q, w_addr;
    logic [VW-1:0] vec_q;
    logic [FW-1:0] dist_q;

    logic [VW-1:0] w_ref, w_mean, mean_nx, wa_ref, wa_mean;
    logic [FW-1:0] w_dth, w_mdth, mdth_nx, wa_dth;
    logic [CW-1:0] w_cnt, n_w, wa_cnt;
    logic          commit, wa_en, wb_en;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid) state_d = (in_dist <= w_dth) ? ST_MATCH : ST_ALLOC;
            ST_MATCH: state_d = ST_IDLE;
            ST_ALLOC: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready = 1'b0;
        new_ref  = 1'b0;
        wa_en    = 1'b0;
        wb_en    = 1'b0;
        unique case (state_q)
            ST_IDLE:  in_ready = 1'b1;
            ST_MATCH: wa_en    = 1'b1;
            ST_ALLOC: begin
                wa_en   = 1'b1;
                wb_en   = 1'b1;
                new_ref = 1'b1;
            end
            default: ;
        endcase
    end
    assign new_slot = ptr_q;

    // result capture and allocation pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            vec_q  <= '0;
            dist_q <= '0;
            ptr_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && in_valid) begin
                idx_q  <= in_idx;
                vec_q  <= in_vec;
                dist_q <= in_dist;
            end
            if (state_q == ST_ALLOC)
                ptr_q <= (ptr_q == IW'(NSLOT - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    assign w_addr = (state_q == ST_IDLE) ? in_idx : idx_q;
    assign n_w    = (w_cnt == CW'(CMAX)) ? w_cnt : w_cnt + 1'b1;
    assign commit = (32'(n_w) > NTH);

    rmu_mean_step #(.W(FW), .CW(CW)) u_dstep (
        .mean_i(w_mdth), .sample_i(dist_q), .n_i(n_w), .mean_o(mdth_nx)
    );

    for (genvar f = 0; f < NF; f++) begin : g_feat
        rmu_mean_step #(.W(FW), .CW(CW)) u_vstep (
            .mean_i  (w_mean[f*FW +: FW]),
            .sample_i(vec_q[f*FW +: FW]),
            .n_i     (n_w),
            .mean_o  (mean_nx[f*FW +: FW])
        );
    end

    always_comb begin
        wa_mean = (state_q == ST_MATCH) ? mean_nx : w_mean;
        wa_ref  = commit ? wa_mean : w_ref;
        wa_dth  = commit ? mdth_nx : w_dth;
        wa_cnt  = commit ? CW'(1) : n_w;
    end

    rmu_slot_table #(
        .NSLOT(NSLOT), .VW(VW), .DW(FW), .CW(CW), .IW(IW)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (w_addr),
        .ra_ref (w_ref),
        .ra_mean(w_mean),
        .ra_dth (w_dth),
        .ra_mdth(w_mdth),
        .ra_cnt (w_cnt),
        .rb_idx (rd_idx),
        .rb_ref (rd_ref),
        .rb_mean(rd_mean),
        .rb_dth (rd_dth),
        .rb_mdth(rd_mdth),
        .rb_cnt (rd_cnt),
        .wa_en  (wa_en),
        .wa_idx (idx_q),
        .wa_ref (wa_ref),
        .wa_mean(wa_mean),
        .wa_dth (wa_dth),
        .wa_mdth(mdth_nx),
        .wa_cnt (wa_cnt),
        .wb_en  (wb_en),
        .wb_idx (ptr_q),
        .wb_vec (vec_q),
        .wb_dth (FW'(INIT_DTH)),
        .wb_cnt (CW'(1))
    );

endmodule

// File: rtl/rmu_checker.sv
module rmu_checker #(
    parameter int IW    = 5,
    parameter int CW    = 6,
    parameter int NSLOT = 32,
    parameter int NTH   = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          new_ref,
    input logic [IW-1:0] new_slot,
    input logic [CW-1:0] rd_cnt
);

    logic [IW-1:0] exp_slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       exp_slot <= '0;
        else if (new_ref) exp_slot <= (exp_slot == IW'(NSLOT - 1)) ? '0 : exp_slot + 1'b1;
    end

    // R1
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R1
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);

    // R2
    new_flag_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_ref |-> !in_ready);

    // R3
    slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_ref |-> (new_slot == exp_slot));

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |-> (in_ready && !new_ref));

    if (NTH < (1 << CW) - 1) begin : g_cnt
        // R6
        cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            32'(rd_cnt) <= NTH);
    end

endmodule

bind ref_mean_updater rmu_checker #(
    .IW(IW), .CW(CW), .NSLOT(NSLOT), .NTH(NTH)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_ready(in_ready),
    .new_ref (new_ref),
    .new_slot(new_slot),
    .rd_cnt  (rd_cnt)
);

// File: tb/ref_mean_updater_bench.sv
module ref_mean_updater_bench;

    localparam int NF = 8, FW = 8, NS = 32, IW = 5, CW = 6, NTH = 32, INIT = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [IW-1:0] in_idx = '0;
    logic [63:0]   in_vec = '0;
    logic [FW-1:0] in_dist = '0;
    logic          new_ref;
    logic [IW-1:0] new_slot;
    logic [IW-1:0] rd_idx = '0;
    logic [63:0]   rd_ref, rd_mean;
    logic [FW-1:0] rd_dth, rd_mdth;
    logic [CW-1:0] rd_cnt;

    always #5 clk = ~clk;

    ref_mean_updater u_ref_mean_updater (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_idx(in_idx), .in_vec(in_vec), .in_dist(in_dist),
        .new_ref(new_ref), .new_slot(new_slot), .rd_idx(rd_idx),
        .rd_ref(rd_ref), .rd_mean(rd_mean), .rd_dth(rd_dth),
        .rd_mdth(rd_mdth), .rd_cnt(rd_cnt)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model
    int m_ref [NS][NF];
    int m_mean[NS][NF];
    int m_dth [NS];
    int m_mdth[NS];
    int m_cnt [NS];
    int m_state = 0;   // 0 idle, 1 known, 2 new
    int m_idx, m_dist, m_ptr;
    int m_vec[NF];

    function automatic int step_mean(input int m, input int s, input int n);
        int k, p, d, q, r;
        if (n % 8 != 0) return m;
        k = (n == 8) ? 3 : (n < 32) ? 4 : 5;
        p = 1 << k;
        d = m - s;
        if (d >= 0) q = d / p;
        else        q = -((-d + p - 1) / p);
        r = m - q;
        if (r < 0)   r = 0;
        if (r > 255) r = 255;
        return r;
    endfunction

    function automatic logic [63:0] pack_ref(input int s);
        logic [63:0] v;
        for (int f = 0; f < NF; f++) v[f*8 +: 8] = 8'(m_ref[s][f]);
        return v;
    endfunction

    function automatic logic [63:0] pack_mean(input int s);
        logic [63:0] v;
        for (int f = 0; f < NF; f++) v[f*8 +: 8] = 8'(m_mean[s][f]);
        return v;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            for (int f = 0; f < NF; f++) begin
                m_ref[s][f]  = 0;
                m_mean[s][f] = 0;
            end
            m_dth[s] = 0; m_mdth[s] = 0; m_cnt[s] = 0;
        end
        m_state = 0; m_ptr = 0; m_idx = 0; m_dist = 0;
    endtask

    task automatic model_apply();
        int w, n, nd;
        int nm[NF];
        w  = m_idx;
        n  = (m_cnt[w] + 1 > 63) ? 63 : m_cnt[w] + 1;
        nd = step_mean(m_mdth[w], m_dist, n);
        for (int f = 0; f < NF; f++)
            nm[f] = (m_state == 1) ? step_mean(m_mean[w][f], m_vec[f], n) : m_mean[w][f];
        for (int f = 0; f < NF; f++) begin
            m_mean[w][f] = nm[f];
            if (n > NTH) m_ref[w][f] = nm[f];
        end
        m_mdth[w] = nd;
        if (n > NTH) begin
            m_dth[w] = nd;
            m_cnt[w] = 1;
        end else begin
            m_cnt[w] = n;
        end
        if (m_state == 2) begin
            for (int f = 0; f < NF; f++) begin
                m_ref[m_ptr][f]  = m_vec[f];
                m_mean[m_ptr][f] = m_vec[f];
            end
            m_dth[m_ptr]  = INIT;
            m_mdth[m_ptr] = INIT;
            m_cnt[m_ptr]  = 1;
            m_ptr = (m_ptr + 1) % NS;
        end
    endtask

    always @(negedge clk) begin
        int r;
        r = int'(rd_idx);
        chk("R1 ready", 64'(in_ready), 64'(m_state == 0));
        chk("R2 new flag", 64'(new_ref), 64'(m_state == 2));
        if (m_state == 2) chk("R3 new slot", 64'(new_slot), 64'(m_ptr));
        chk("R9 read active vector", rd_ref, pack_ref(r));
        chk("R4 vector mean", rd_mean, pack_mean(r));
        chk("R6 active threshold", 64'(rd_dth), 64'(m_dth[r]));
        chk("R5 distance mean", 64'(rd_mdth), 64'(m_mdth[r]));
        chk("R7 counter", 64'(rd_cnt), 64'(m_cnt[r]));
        if (!rst_n) begin
            model_reset();
        end else if (m_state == 0) begin
            if (in_valid) begin
                m_idx  = int'(in_idx);
                m_dist = int'(in_dist);
                for (int f = 0; f < NF; f++) m_vec[f] = int'(in_vec[f*8 +: 8]);
                m_state = (m_dist <= m_dth[m_idx]) ? 1 : 2;
            end
        end else begin
            model_apply();
            m_state = 0;
        end
        rd_idx <= rd_idx + 1'b1;
    end

    int unsigned seed = 32'h1234_5678;
    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed >> 8;
    endfunction

    function automatic logic [63:0] rvec();
        logic [63:0] v;
        for (int f = 0; f < NF; f++) begin
            int unsigned x;
            x = rnd() % 10;
            v[f*8 +: 8] = (x == 0) ? 8'd0 : (x == 1) ? 8'd255 : 8'(rnd());
        end
        return v;
    endfunction

    task automatic send(input int idx, input logic [63:0] v, input int d);
        @(posedge clk); #1;
        in_valid = 1'b1; in_idx = IW'(idx); in_vec = v; in_dist = FW'(d);
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(posedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        #2;
        // R8 reset state seen at the ports
        chk("R8 reset ready", 64'(in_ready), 64'd1);
        chk("R8 reset new flag", 64'(new_ref), 64'd0);
        chk("R8 reset counter", 64'(rd_cnt), 64'd0);
        @(posedge clk); #1 rst_n = 1'b1;

        // new reference: empty winner threshold 0, distance 3 -> seeds slot 0
        send(5, 64'h0807_0605_0403_0201, 3);
        // many known samples to slot 0: counts 8,16,24,32 and commit at 33
        for (int i = 0; i < 40; i++) send(0, rvec(), i % 11);
        // out-of-threshold distance for slot 0
        send(0, rvec(), 200);
        // seeded slot equals winner
        send(m_ptr, rvec(), 255);
        // continuous valid burst: every other result ignored while busy (R1)
        @(posedge clk); #1;
        in_valid = 1'b1;
        for (int i = 0; i < 20; i++) begin
            in_idx = IW'(rnd()); in_vec = rvec(); in_dist = FW'(rnd() % 16);
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        // mixed traffic, wraps the allocation order
        for (int i = 0; i < 400; i++) begin
            int w;
            w = (rnd() % 4 == 0) ? int'(rnd() % NS) : int'(rnd() % 4);
            send(w, rvec(), int'(rnd() % 14));
            if (rnd() % 3 == 0) repeat (int'(rnd() % 3)) @(posedge clk);
        end
        repeat (40) @(posedge clk);
        finish_run();
    end

endmodule